// File: doc/BRIEF.md
# Melody Tone Generator

This block plays a tune from an external melody ROM and drives a single piezo output bit, so the processor does not have to toggle a pin at audio rate. The processor loads a start address into the block and sets the play enable. After that the block reads one command per ROM address. On every divider tick it runs a four-phase duty sequence whose phase lengths come from a built-in cycle table. A duration counter decides when to step to the next ROM address.

Each command has three fields. A 4-bit tone code selects the pitch row entry. An octave bit halves the pitch by doubling every phase length. A long bit doubles the note length. Two tone codes are special: one marks a rest and the other raises a stop flag that the processor can poll. The piezo bit is high only in the odd duty phases, and only while playback is enabled.

Top module: `mel_tone_gen`

## Requirements
- R1: The command is `rom_cmd_i[5:0]`. Bits 3:0 are the tone code, bit 4 is the octave bit and bit 5 is the long-note bit.
- R2: For tone codes 2 to 13, each tick of `tick_i` advances a duty counter. Duty phase p lasts L(p, code) ticks, then the phase steps p -> p+1 modulo 4. L is taken from these rows, each listed for codes 2..13. Phase 0: 7 8 8 9 9 10 11 11 12 13 14 14. Phase 1: 8 8 9 9 10 11 11 12 13 13 14 15. Phase 2: 8 8 9 9 10 10 11 12 12 13 14 15. Phase 3: 8 9 9 10 10 11 11 12 13 14 14 15.
- R3: When the octave bit is 0, every phase length is twice the table value. When it is 1, the table value is used as is.
- R4: `piezo_o` is a register. On each tick it takes (phase is odd) AND (enable set) AND (tone code in 2..13). After a load with enable set, the first rising edge of `piezo_o` comes L(0)+1 ticks after the load cycle. It then stays high for L(1), low for L(2), high for L(3) and low for L(0).
- R5: Tone code 0 (rest) and tone codes 14 and 15 keep `piezo_o` at 0.
- R6: On a tick, tone code 1 sets `stop_o`. `stop_o` then stays set until the next load.
- R7: A tick with `(div_i & STEP_MASK) == 0` is a step tick. The ROM address advances by one after 16 step ticks, or after 32 when the long bit is 1.
- R8: `load_i` sets `rom_addr_o` to `start_addr_i` and clears the duty counter, the duty phase, the step counter and `stop_o`. A load takes priority over a tick in the same cycle.
- R9: Without `tick_i` (and without a load), `rom_addr_o`, `piezo_o` and `stop_o` hold their values.
- R10: Reset clears the enable, the address, `piezo_o` and `stop_o`. Until the enable is written to 1, `piezo_o` stays 0 even while a tone command is playing.
- R11: Writing the enable (`en_we_i`, value `en_i`) changes only the output gating. Setting it while a tone plays makes `piezo_o` toggle without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Divider tick strobe |
| div_i | input | DIV_W | Divider value seen at the tick |
| load_i | input | 1 | Load start address |
| start_addr_i | input | ADDR_W | Start address of the tune |
| en_we_i | input | 1 | Enable write strobe |
| en_i | input | 1 | Enable value to write |
| rom_addr_o | output | ADDR_W | Melody ROM address |
| rom_cmd_i | input | 6 | Low six bits of the ROM byte at `rom_addr_o` |
| piezo_o | output | 1 | Piezo drive bit |
| stop_o | output | 1 | Stop flag |

## Verification
The bench builds the block with `DIV_W = 8` and `STEP_MASK = 8'h07`. With these values one step tick comes every eight ticks, so a short note lasts 128 ticks and a long note 256. That lets a whole four-phase pitch cycle, even the slowest doubled one of about 150 ticks, fit inside one long note and be timed edge by edge. It also keeps the 16- and 32-step note lengths short enough to count directly. The tone vectors cover both octave settings and tone codes at the low end, in the middle and at the top of the table.

// File: rtl/mel_pkg.sv
package mel_pkg;

  localparam int unsigned TONE_W = 4;
  localparam logic [TONE_W-1:0] CODE_STOP = 4'd1;
  localparam logic [TONE_W-1:0] TONE_LO   = 4'd2;
  localparam logic [TONE_W-1:0] TONE_HI   = 4'd13;

  // phase length per tone code, one nibble per code, code 0 in the low nibble
  localparam logic [63:0] LEN_PH0 = 64'h00EEDCBBA9988700;
  localparam logic [63:0] LEN_PH1 = 64'h00FEDDCBBA998800;
  localparam logic [63:0] LEN_PH2 = 64'h00FEDCCBAA998800;
  localparam logic [63:0] LEN_PH3 = 64'h00FEEDCBBAA99800;

  typedef struct packed {
    logic              long_note;
    logic              oct;
    logic [TONE_W-1:0] tone;
  } mel_cmd_t;

  function automatic logic [3:0] phase_len(input logic [1:0] phase, input logic [TONE_W-1:0] code);
    logic [5:0] sel;
    sel = {code, 2'b00};
    case (phase)
      2'd0:    phase_len = LEN_PH0[sel +: 4];
      2'd1:    phase_len = LEN_PH1[sel +: 4];
      2'd2:    phase_len = LEN_PH2[sel +: 4];
      default: phase_len = LEN_PH3[sel +: 4];
    endcase
  endfunction

endpackage

// File: rtl/mel_duty.sv
module mel_duty
  import mel_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              active_i,
  input  logic [TONE_W-1:0] tone_i,
  input  logic              oct_i,
  output logic [1:0]        phase_o
);

  logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
  logic [1:0]       phase_q;

  always_comb begin
    limit = CNT_W'(phase_len(phase_q, tone_i));
    if (!oct_i) limit = limit << 1;
    cnt_inc = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (tick_i && active_i) begin
      if (cnt_inc >= limit) begin
        cnt_q   <= '0;
        phase_q <= phase_q + 2'd1;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/mel_step.sv
module mel_step #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STEP_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              step_hit_i,
  input  logic              long_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [STEP_W-1:0] MASK_LONG  = '1;
  localparam logic [STEP_W-1:0] MASK_SHORT = MASK_LONG >> 1;

  logic [STEP_W-1:0] step_q, step_nxt;
  logic [ADDR_W-1:0] addr_q;

  assign step_nxt = (step_q + 1'b1) & (long_i ? MASK_LONG : MASK_SHORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      step_q <= '0;
      addr_q <= load_addr_i;
    end else if (tick_i && step_hit_i) begin
      step_q <= step_nxt;
      if (step_nxt == '0) addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/mel_tone_gen.sv
module mel_tone_gen
  import mel_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 15,
  parameter logic [DIV_W-1:0] STEP_MASK = DIV_W'(8'h7F)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              en_we_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [5:0]        rom_cmd_i,
  output logic              piezo_o,
  output logic              stop_o
);

  localparam int unsigned CNT_W = 5;

  mel_cmd_t   cmd;
  logic       tone_on, step_hit, out_bit;
  logic       en_q, stop_q, piezo_q;
  logic [1:0] phase;

  assign cmd      = mel_cmd_t'(rom_cmd_i);
  assign tone_on  = (cmd.tone >= TONE_LO) && (cmd.tone <= TONE_HI);
  assign step_hit = (div_i & STEP_MASK) == '0;

  mel_duty #(.CNT_W(CNT_W)) u_duty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (load_i),
    .active_i(tone_on),
    .tone_i  (cmd.tone),
    .oct_i   (cmd.oct),
    .phase_o (phase)
  );

  mel_step #(.ADDR_W(ADDR_W), .STEP_W(5)) u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .step_hit_i (step_hit),
    .long_i     (cmd.long_note),
    .load_i     (load_i),
    .load_addr_i(start_addr_i),
    .addr_o     (rom_addr_o)
  );

  assign out_bit = tone_on & phase[0] & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      piezo_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_i;
      if (load_i) begin
        stop_q <= 1'b0;
      end else if (tick_i) begin
        if (cmd.tone == CODE_STOP) stop_q <= 1'b1;
        if (out_bit != piezo_q) piezo_q <= out_bit;
      end
    end
  end

  assign piezo_o = piezo_q;
  assign stop_o  = stop_q;

endmodule

// File: rtl/mel_tone_gen_chk.sv
module mel_tone_gen_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 15,
  parameter logic [DIV_W-1:0] STEP_MASK = DIV_W'(8'h7F)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [DIV_W-1:0]  div_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [5:0]        rom_cmd_i,
  input logic              piezo_o,
  input logic              stop_o,
  input logic              en_q
);

  assert_gated_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !en_q) |=> !piezo_o);

  assert_silent_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && ((rom_cmd_i[3:0] < 4'd2) || (rom_cmd_i[3:0] > 4'd13))) |=> !piezo_o);

  assert_stop_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !load_i) |=> stop_o);

  assert_no_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && ((div_i & STEP_MASK) != '0)) |=> $stable(rom_addr_o));

  assert_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((rom_addr_o == $past(start_addr_i)) && !stop_o));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> ($stable(rom_addr_o) && $stable(piezo_o) && $stable(stop_o)));

endmodule

bind mel_tone_gen mel_tone_gen_chk #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .STEP_MASK(STEP_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .div_i(div_i),
  .load_i(load_i), .start_addr_i(start_addr_i), .rom_addr_o(rom_addr_o),
  .rom_cmd_i(rom_cmd_i), .piezo_o(piezo_o), .stop_o(stop_o), .en_q(en_q)
);

// File: tb/mel_tone_gen_test.sv
module mel_tone_gen_test;

  localparam logic [7:0] MASK = 8'h07;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] div = '0;
  logic       load = 1'b0;
  logic [7:0] start_addr = '0;
  logic       en_we = 1'b0;
  logic       en = 1'b0;
  logic [7:0] rom_addr;
  logic [5:0] rom_cmd;
  logic       piezo, stop;
  logic [7:0] rom [256];

  int n_chk = 0;
  int n_bad = 0;
  int qual_cnt = 0;

  // cmd, phase0..phase3 lengths in ticks
  localparam logic [39:0] VECS [6] = '{
    40'h22_0E_10_10_10,
    40'h32_07_08_08_08,
    40'h3D_0E_0F_0F_0F,
    40'h37_0A_0B_0A_0B,
    40'h29_16_18_18_18,
    40'h2D_1C_1E_1E_1E
  };

  always #10 clk = ~clk;

  assign rom_cmd = rom[rom_addr][5:0];

  mel_tone_gen #(.ADDR_W(8), .DIV_W(8), .STEP_MASK(MASK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .div_i(div),
    .load_i(load), .start_addr_i(start_addr), .en_we_i(en_we), .en_i(en),
    .rom_addr_o(rom_addr), .rom_cmd_i(rom_cmd), .piezo_o(piezo), .stop_o(stop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv();
    bit q;
    q = tick && ((div & MASK) == 8'h00) && !load;
    @(posedge clk);
    #2;
    if (q) qual_cnt++;
    if (tick) div = div + 8'd1;
    load  = 1'b0;
    en_we = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] a, input bit wr_en);
    load = 1'b1;
    start_addr = a;
    en_we = wr_en;
    en = 1'b1;
    adv();
  endtask

  task automatic idle_off();
    en_we = 1'b1;
    en = 1'b0;
    adv();
    adv();
    adv();
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) rom[a] = 8'h00;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 3; j++) rom[16*i+j] = VECS[i][39:32];
    rom[8'h80] = 8'h20; rom[8'h81] = 8'h20;
    rom[8'h90] = 8'h2E; rom[8'h91] = 8'h2E;
    rom[8'hA0] = 8'h01;
    rom[8'hB0] = 8'h02; rom[8'hB1] = 8'h02;
    rom[8'hC0] = 8'h22; rom[8'hC1] = 8'h22;

    #45;
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(piezo == 1'b0, "R10 piezo", piezo, 0);
    chk(stop == 1'b0, "R10 stop", stop, 0);
    chk(rom_addr == 8'h00, "R10 addr", rom_addr, 0);

    // R10: enable cleared by reset, tone plays silently
    begin
      int highs = 0;
      do_load(8'h10, 1'b0);
      for (int e = 0; e < 60; e++) begin adv(); if (piezo) highs++; end
      chk(highs == 0, "R10 enable off", highs, 0);
    end

    // R11: enable write alone starts output
    begin
      bit rose = 1'b0;
      en_we = 1'b1; en = 1'b1; adv();
      for (int e = 0; e < 40; e++) begin adv(); if (piezo) rose = 1'b1; end
      chk(rose, "R11 enable write", rose, 1);
    end

    // R1 R2 R3 R4 R8: vector walk, reload mid-tone clears duty state
    for (int i = 0; i < 6; i++) begin
      int t [5];
      int k;
      bit prev;
      k = 0;
      prev = 1'b0;
      for (int m = 0; m < 5; m++) t[m] = 0;
      idle_off();
      do_load(8'(16*i), 1'b1);
      for (int e = 1; e <= 300 && k < 5; e++) begin
        adv();
        if (piezo != prev) begin t[k] = e; k++; prev = piezo; end
      end
      chk(t[0] == int'(VECS[i][31:24]) + 1, "R4 R8 first rise", t[0], int'(VECS[i][31:24]) + 1);
      chk(t[1] - t[0] == int'(VECS[i][23:16]), "R2 R3 phase1", t[1] - t[0], int'(VECS[i][23:16]));
      chk(t[2] - t[1] == int'(VECS[i][15:8]), "R2 R3 phase2", t[2] - t[1], int'(VECS[i][15:8]));
      chk(t[3] - t[2] == int'(VECS[i][7:0]), "R2 R1 phase3", t[3] - t[2], int'(VECS[i][7:0]));
      chk(t[4] - t[3] == int'(VECS[i][31:24]), "R2 R4 phase0", t[4] - t[3], int'(VECS[i][31:24]));
    end

    // R5: rest and illegal codes silent
    begin
      int highs = 0;
      idle_off();
      do_load(8'h80, 1'b1);
      for (int e = 0; e < 100; e++) begin adv(); if (piezo) highs++; end
      chk(highs == 0, "R5 rest", highs, 0);
      highs = 0;
      do_load(8'h90, 1'b1);
      for (int e = 0; e < 100; e++) begin adv(); if (piezo) highs++; end
      chk(highs == 0, "R5 illegal", highs, 0);
    end

    // R6 R8: stop flag set, held, cleared by load
    do_load(8'hA0, 1'b1);
    chk(stop == 1'b0, "R8 stop after load", stop, 0);
    adv();
    chk(stop == 1'b1, "R6 stop set", stop, 1);
    for (int e = 0; e < 20; e++) adv();
    chk(stop == 1'b1, "R6 stop held", stop, 1);
    do_load(8'h80, 1'b1);
    chk(stop == 1'b0, "R8 stop cleared", stop, 0);

    // R7 R1: note duration, short and long
    for (int n = 0; n < 2; n++) begin
      logic [7:0] base;
      base = (n == 0) ? 8'hB0 : 8'hC0;
      do_load(base, 1'b1);
      qual_cnt = 0;
      for (int e = 0; e < 400; e++) begin
        adv();
        if (rom_addr != base) break;
      end
      chk(rom_addr == base + 8'd1, "R7 next addr", rom_addr, base + 8'd1);
      chk(qual_cnt == (n == 0 ? 16 : 32), "R7 R1 step ticks", qual_cnt, (n == 0 ? 16 : 32));
    end

    // R9: no tick, nothing moves
    begin
      logic [7:0] a0;
      logic       p0;
      int         moved = 0;
      do_load(8'h20, 1'b1);
      for (int e = 0; e < 20; e++) adv();
      tick = 1'b0;
      adv();
      a0 = rom_addr;
      p0 = piezo;
      for (int e = 0; e < 40; e++) begin
        adv();
        if (rom_addr != a0 || piezo != p0) moved++;
      end
      chk(moved == 0, "R9 hold without tick", moved, 0);
      tick = 1'b1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule